// File: doc/BRIEF.md
# I/O Window Wait-State Controller

This block lets a secondary bus master serve I/O accesses made by an 8-bit CPU. It watches the CPU address bus. When a valid memory access falls inside a fixed I/O window, it stalls the CPU by pulling the memory-ready line low. It then raises a request flag toward the peripheral controller. The peripheral controller moves the data and answers with an active-low grant pulse. That pulse releases the stall, and the CPU latches its data on the next falling edge of E.

The CPU's registers are dynamic, so it cannot be held not-ready indefinitely. A stretch timer forces ready high after a configurable number of system clocks (6 µs by default) and sets a sticky error flag. After a release, the stall is not re-armed until the current bus cycle has really finished. This stops a long grant pulse or a lingering address from stalling the same cycle twice. The E clock and the grant strobe are asynchronous to the system clock and are synchronized inside the block.

Top module: `iowin_wait_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `mrdy` is 1, `io_req` is 0 and `stretch_err` is 0 after that edge.
- R2: A hit is a cycle with `cpu_vma` = 1 and `cpu_addr` inside 0xB000..0xB3FF, both limits included. A hit seen in idle drives `mrdy` to 0 and `io_req` to 1 from the next clock edge onward.
- R3: Addresses outside the window (including 0xAFFF and 0xB400), and any address while `cpu_vma` = 0, leave `mrdy` at 1 and `io_req` at 0.
- R4: A high-to-low transition of `grant_n` while the block is waiting returns `mrdy` to 1 and `io_req` to 0 on the third clock edge after the transition. That delay is two synchronizer stages plus one state update.
- R5: Only a falling transition of `grant_n` counts. If `grant_n` is already low when the wait begins, the stall holds until `grant_n` rises and falls again.
- R6: After a release, `mrdy` stays 1 while the address remains in the window. The block re-arms only after E has fallen and then either the address leaves the window or E rises to start a new cycle.
- R7: `mrdy` is never low for more than STRETCH_LIMIT consecutive clocks (default 1200, which is 6 µs at 200 MHz). When the limit is reached with no grant, `mrdy` goes to 1, `io_req` to 0 and `stretch_err` to 1.
- R8: `stretch_err` stays 1 until reset, and later requests are still stalled and released normally.
- R9: If the grant falling edge is detected in the same cycle the limit is reached, the grant wins and `stretch_err` stays 0.
- R10: Activity on `grant_n` while idle has no effect: outputs stay idle, and a later hit still stalls until a fresh grant edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_vma | input | 1 | CPU valid-memory-address qualifier |
| cpu_e | input | 1 | CPU E clock (asynchronous) |
| grant_n | input | 1 | Grant strobe from peripheral controller, active low (asynchronous) |
| mrdy | output | 1 | Memory-ready to CPU; low stretches the cycle |
| io_req | output | 1 | High while waiting for grant |
| stretch_err | output | 1 | Sticky flag: a stall hit the time limit |

## Verification
Two functions can act in the same clock cycle: the synchronized grant falling edge and the stretch timer reaching its final count. The bench provokes this by timing the `grant_n` fall so that its detection lands exactly on the last permitted stall cycle. It checks that the release is taken as a grant with no error flag. It then repeats the run with the fall one cycle later and expects the timeout path instead, with the error flag set.

// File: rtl/iowin_pkg.sv
// Shared types for the I/O window wait-state controller.
package iowin_pkg;

    // Controller phases: idle, stalling the CPU, released but cycle not yet over.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HELD = 2'd2
    } wait_state_e;

endpackage

// File: rtl/iowin_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes the input is a slow level (E clock, grant strobe) whose
// high and low phases each last several system clocks.
module iowin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d_async;
    end

    // Remaining stages shift the sampled value along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/iowin_decode.sv
// Address window decoder: flags a valid access inside [WIN_LO, WIN_HI].
// Assumes the address and VMA are stable for the system clock that samples them.
module iowin_decode #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_LO = 16'hB000,
    parameter logic [ADDR_W-1:0] WIN_HI = 16'hB3FF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              vma,
    output logic              hit
);

    // Inclusive range compare qualified by VMA.
    always_comb begin
        hit = vma && (addr >= WIN_LO) && (addr <= WIN_HI);
    end

endmodule

// File: rtl/iowin_stretch_timer.sv
// Counts clocks while a stall is active and flags the final permitted one.
// Assumes 'run' stays high for a whole stall and drops between stalls.
module iowin_stretch_timer #(
    parameter int LIMIT = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Advance while stalling; restart from zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // The last permitted stall cycle.
    always_comb begin
        expire = run && (cnt == LAST);
    end

endmodule

// File: rtl/iowin_wait_ctrl.sv
// I/O window wait-state controller (top).
// Stalls the CPU on an I/O window hit, requests service, and releases on a
// grant falling edge or on the stretch limit. It re-arms only after the bus
// cycle ends. Assumes cpu_e and grant_n are asynchronous and cpu_addr/cpu_vma
// are synchronous to clk.
module iowin_wait_ctrl
    import iowin_pkg::*;
#(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] WIN_LO        = 16'hB000,
    parameter logic [ADDR_W-1:0] WIN_HI        = 16'hB3FF,
    parameter int                SYNC_STAGES   = 2,
    parameter int                STRETCH_LIMIT = 1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_vma,
    input  logic              cpu_e,
    input  logic              grant_n,
    output logic              mrdy,
    output logic              io_req,
    output logic              stretch_err
);

    wait_state_e state, nxt;
    logic win_hit, e_s, e_prev, g_s, g_prev;
    logic e_fall, e_rise, grant_fall, tmr_expire, e_fell_q;

    iowin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_e (
        .clk(clk), .rst_n(rst_n), .d_async(cpu_e), .q_sync(e_s));

    iowin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_g (
        .clk(clk), .rst_n(rst_n), .d_async(grant_n), .q_sync(g_s));

    iowin_decode #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
        .addr(cpu_addr), .vma(cpu_vma), .hit(win_hit));

    iowin_stretch_timer #(.LIMIT(STRETCH_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT), .expire(tmr_expire));

    // Previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_prev <= 1'b0;
            g_prev <= 1'b1;
        end else begin
            e_prev <= e_s;
            g_prev <= g_s;
        end
    end

    // Edge strobes on the synchronized E clock and grant.
    always_comb begin
        e_fall     = e_prev && !e_s;
        e_rise     = !e_prev && e_s;
        grant_fall = g_prev && !g_s;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (win_hit) nxt = ST_WAIT;
            ST_WAIT: if (grant_fall || tmr_expire) nxt = ST_HELD;
            ST_HELD: if (e_fell_q && (!win_hit || e_rise)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Records that E has fallen since the stall was released.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_WAIT) e_fell_q <= 1'b0;
        else if (state == ST_HELD && e_fall) e_fell_q <= 1'b1;
    end

    // Sticky error: the limit was reached without a grant in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stretch_err <= 1'b0;
        else if (state == ST_WAIT && tmr_expire && !grant_fall) stretch_err <= 1'b1;
    end

    // Outputs come straight from the state register, so they are glitch free.
    always_comb begin
        mrdy   = (state != ST_WAIT);
        io_req = (state == ST_WAIT);
    end

endmodule

// File: rtl/iowin_wait_chk.sv
// Checker for iowin_wait_ctrl, attached by bind. Observes ports and the
// internal strobes; drives nothing.
module iowin_wait_chk
    import iowin_pkg::*;
#(
    parameter int STRETCH_LIMIT = 1200
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mrdy,
    input logic        io_req,
    input logic        stretch_err,
    input logic        win_hit,
    input logic        grant_fall,
    input logic        e_fell_q,
    input wait_state_e state
);

    localparam int LW = $clog2(STRETCH_LIMIT + 2);
    logic [LW-1:0] low_run;

    // Length of the current run of not-ready cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || mrdy) low_run <= '0;
        else if (low_run != '1) low_run <= low_run + 1'b1;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (mrdy && !io_req && !stretch_err));

    assert_hit_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && win_hit) |=> (!mrdy && io_req));

    assert_miss_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !win_hit) |=> (mrdy && !io_req));

    assert_grant_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && grant_fall) |=> (mrdy && !io_req));

    assert_no_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !e_fell_q) |=> mrdy);

    assert_stretch_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LW'(STRETCH_LIMIT));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_err |=> stretch_err);

    assert_grant_beats_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && grant_fall) |=> !$rose(stretch_err));

endmodule

bind iowin_wait_ctrl iowin_wait_chk #(.STRETCH_LIMIT(STRETCH_LIMIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .mrdy(mrdy), .io_req(io_req),
    .stretch_err(stretch_err), .win_hit(win_hit), .grant_fall(grant_fall),
    .e_fell_q(e_fell_q), .state(state));

// File: tb/test_iowin_wait_ctrl.sv
module test_iowin_wait_ctrl;

    localparam int LIMIT = 1200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_vma = 1'b0;
    logic        cpu_e = 1'b0;
    logic        grant_n = 1'b1;
    logic        mrdy, io_req, stretch_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    iowin_wait_ctrl #(.STRETCH_LIMIT(LIMIT)) i_iowin_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_vma(cpu_vma),
        .cpu_e(cpu_e), .grant_n(grant_n), .mrdy(mrdy), .io_req(io_req),
        .stretch_err(stretch_err));

    // {address, vma, expect stall}
    localparam logic [17:0] VEC [8] = '{
        {16'hB000, 1'b1, 1'b1},   // R2 low limit
        {16'hB3FF, 1'b1, 1'b1},   // R2 high limit
        {16'hB200, 1'b1, 1'b1},   // R2 interior
        {16'hAFFF, 1'b1, 1'b0},   // R3 below
        {16'hB400, 1'b1, 1'b0},   // R3 above
        {16'hB000, 1'b0, 1'b0},   // R3 no vma
        {16'h0000, 1'b1, 1'b0},   // R3 bottom
        {16'hFFFF, 1'b1, 1'b0}    // R3 top
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_addr = '0; cpu_vma = 1'b0; cpu_e = 1'b0; grant_n = 1'b1;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic grant_pulse();
        grant_n = 1'b0;
        wait_cyc(5);
        grant_n = 1'b1;
        wait_cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int lows;
        // R1 reset state
        do_reset();
        chk("R1 mrdy", mrdy, 1);
        chk("R1 io_req", io_req, 0);
        chk("R1 stretch_err", stretch_err, 0);

        // Vector table: R2/R3 decode
        foreach (VEC[i]) begin
            do_reset();
            cpu_addr = VEC[i][17:2];
            cpu_vma  = VEC[i][1];
            wait_cyc(1);
            chk(VEC[i][0] ? "R2 mrdy" : "R3 mrdy", mrdy, VEC[i][0] ? 0 : 1);
            chk(VEC[i][0] ? "R2 io_req" : "R3 io_req", io_req, VEC[i][0] ? 1 : 0);
            wait_cyc(6);
            chk(VEC[i][0] ? "R2 held" : "R3 held", mrdy, VEC[i][0] ? 0 : 1);
        end

        // R4 exact release latency
        do_reset();
        cpu_addr = 16'hB010; cpu_vma = 1'b1;
        wait_cyc(4);
        grant_n = 1'b0;
        wait_cyc(2);
        chk("R4 still stalled", mrdy, 0);
        wait_cyc(1);
        chk("R4 mrdy released", mrdy, 1);
        chk("R4 io_req cleared", io_req, 0);
        chk("R4 no err", stretch_err, 0);

        // R6: no re-stall while in window before E falls
        wait_cyc(10);
        grant_n = 1'b1;
        wait_cyc(6);
        chk("R6 no restall before E fall", mrdy, 1);
        cpu_e = 1'b1;
        wait_cyc(6);
        chk("R6 E rise alone no restall", mrdy, 1);
        cpu_e = 1'b0;
        wait_cyc(6);
        chk("R6 after E fall same addr", mrdy, 1);
        cpu_e = 1'b1;        // new cycle, still in window
        wait_cyc(5);
        chk("R6 new cycle restalls", mrdy, 0);
        grant_pulse();
        chk("R6 released again", mrdy, 1);
        cpu_e = 1'b0;
        wait_cyc(6);
        cpu_vma = 1'b0;
        wait_cyc(4);
        cpu_vma = 1'b1;      // address re-enters window
        wait_cyc(2);
        chk("R6 leave and return restalls", mrdy, 0);

        // R5: grant already low at start of wait
        do_reset();
        grant_n = 1'b0;
        wait_cyc(5);
        cpu_addr = 16'hB123; cpu_vma = 1'b1;
        wait_cyc(20);
        chk("R5 level low ignored", mrdy, 0);
        grant_n = 1'b1;
        wait_cyc(5);
        grant_n = 1'b0;
        wait_cyc(4);
        chk("R5 fresh edge releases", mrdy, 1);

        // R10: grant activity while idle
        do_reset();
        for (int t = 0; t < 3; t++) begin
            grant_n = 1'b0; wait_cyc(4);
            grant_n = 1'b1; wait_cyc(4);
        end
        chk("R10 idle mrdy", mrdy, 1);
        chk("R10 idle io_req", io_req, 0);
        cpu_addr = 16'hB001; cpu_vma = 1'b1;
        wait_cyc(10);
        chk("R10 later hit still stalls", mrdy, 0);

        // R7: timeout length and flags
        do_reset();
        cpu_addr = 16'hB300; cpu_vma = 1'b1;
        @(posedge clk); @(negedge clk);
        lows = 0;
        while (!mrdy && lows < LIMIT + 10) begin
            lows++;
            @(negedge clk);
        end
        chk("R7 stall length", lows, LIMIT);
        chk("R7 io_req cleared", io_req, 0);
        chk("R7 err set", stretch_err, 1);

        // R8: sticky and operation continues
        cpu_e = 1'b1; wait_cyc(5);
        cpu_e = 1'b0; wait_cyc(5);
        cpu_vma = 1'b0; wait_cyc(3);
        cpu_vma = 1'b1; wait_cyc(3);
        chk("R8 new stall", mrdy, 0);
        grant_pulse();
        chk("R8 released", mrdy, 1);
        chk("R8 err sticky", stretch_err, 1);

        // R9: grant detected on the final stall cycle
        do_reset();
        cpu_addr = 16'hB0F0; cpu_vma = 1'b1;
        repeat (LIMIT - 2) @(posedge clk);
        @(negedge clk);
        grant_n = 1'b0;
        wait_cyc(4);
        chk("R9 coincident mrdy", mrdy, 1);
        chk("R9 coincident no err", stretch_err, 0);

        // R9 contrast: one cycle late, timeout path wins
        do_reset();
        cpu_addr = 16'hB0F0; cpu_vma = 1'b1;
        repeat (LIMIT - 1) @(posedge clk);
        @(negedge clk);
        grant_n = 1'b0;
        wait_cyc(4);
        chk("R9 late grant err", stretch_err, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule